// File: doc/BRIEF.md
# Two-Port GPIO Controller with Pin-Mapped Peripheral Lines

This block is a small register-mapped general-purpose I/O controller with two ports. Each port has an output latch, an output-enable mask and a pin-state view. A processor reaches them over a simple word-organised bus: a byte address, write data, a write strobe, a read strobe, and read data that arrives one cycle after the read strobe. Some bit positions of the two ports are wired to on-board peripherals.

The first port carries the control strobes of a NAND flash: address latch, command latch and chip enable. Its pin-state view also reports the flash's ready line. The second port drives a bit-banged serial sensor. Software toggles one bit of the output latch to make a clock edge, and the data bit is presented with that edge. The sensor's serial return line shows up in the second port's pin-state view.

Every other word in the register window is a plain read/write storage word. The pin-state view does not read its storage word back. It is computed as the output latch masked by the enable, with the live peripheral input merged at its fixed bit.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset, every storage word reads back as zero, read data is zero, and the flash control lines, the serial clock, the serial data and the edge strobe are all low.
- R2: The word index is the byte address with its two low bits dropped. Those two bits have no effect on reads or writes.
- R3: Word indices 0 to 22 (byte addresses below 0x5C) are read/write storage, with the exceptions in R4 and R5. A write to index 0x01 or 0x11 is stored but does not change what that index reads. Writes at index 23 or above are dropped, and reads there return zero.
- R4: A read of index 0x01 returns the word at index 0x00 ANDed with the word at index 0x02, with the flash ready input ORed into bit 7.
- R5: A read of index 0x11 returns the word at index 0x10 ANDed with the word at index 0x12, with the sensor return input ORed into bit 4.
- R6: In the cycle after a write to index 0x00, the address-latch line equals bit 6 of the written value, the command-latch line equals bit 5, and chip enable equals bit 4.
- R7: A write to index 0x10 whose bit 1 differs from bit 1 of the stored word raises the edge strobe for exactly the next cycle. From that cycle the serial clock equals the new bit 1 and the serial data equals bit 4 of the written value.
- R8: A write to index 0x10 that leaves bit 1 unchanged stores the value but raises no edge strobe and leaves the serial clock and serial data unchanged.
- R9: Read data is loaded only on the clock edge that samples the read strobe and is held otherwise. When a read and a write target the same word in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_re |
| nand_ready_i | input | 1 | Flash ready line |
| nand_ale_o | output | 1 | Flash address-latch line |
| nand_cle_o | output | 1 | Flash command-latch line |
| nand_ce_o | output | 1 | Flash chip enable |
| sens_sdi_i | input | 1 | Serial return line from the sensor |
| sens_sclk_o | output | 1 | Serial clock level |
| sens_sdo_o | output | 1 | Serial data presented with the last edge |
| sens_edge_o | output | 1 | One-cycle strobe marking a serial clock edge |

## Verification
The colliding pair is a read and a write that land on the same word in one cycle. That word can be a plain storage word or a port's output latch feeding a pin-state view. The bench drives the read and write strobes together on one address and expects the pre-write value. It then reads the same word again and expects the new value. The serial-edge logic and the pin-state read path are also exercised back to back. The edge strobe and the read data are judged in their own cycles against values the bench works out from the write history.

// File: rtl/gpio_pm_pkg.sv
package gpio_pm_pkg;
  // Word indices with special meaning
  localparam int IDX_A_DOUT = 'h00;
  localparam int IDX_A_PINS = 'h01;
  localparam int IDX_A_OE   = 'h02;
  localparam int IDX_D_DOUT = 'h10;
  localparam int IDX_D_PINS = 'h11;
  localparam int IDX_D_OE   = 'h12;
  // Fixed bit positions
  localparam int BIT_ALE    = 6;
  localparam int BIT_CLE    = 5;
  localparam int BIT_CE     = 4;
  localparam int BIT_RDY    = 7;
  localparam int BIT_SCLK   = 1;
  localparam int BIT_SDATA  = 4;
  localparam int BIT_SRET   = 4;
endpackage

// File: rtl/gpio_pm_regs.sv
module gpio_pm_regs #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 23,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword,
  output logic [DATA_W-1:0] a_dout,
  output logic [DATA_W-1:0] a_oe,
  output logic [DATA_W-1:0] d_dout,
  output logic [DATA_W-1:0] d_oe
);
  import gpio_pm_pkg::*;

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '0;
      end else if (we && (idx == IDX_W'(i))) begin
        words[i] <= wdata;
      end
    end
  end

  always_comb begin
    rword = '0;
    if (idx < IDX_W'(NUM_WORDS)) begin
      rword = words[idx];
    end
  end

  assign a_dout = words[IDX_A_DOUT];
  assign a_oe   = words[IDX_A_OE];
  assign d_dout = words[IDX_D_DOUT];
  assign d_oe   = words[IDX_D_OE];
endmodule

// File: rtl/gpio_pm_nand.sv
module gpio_pm_nand (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [2:0] ctl,   // {ale, cle, ce}
  output logic       ale,
  output logic       cle,
  output logic       ce
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ale <= 1'b0;
      cle <= 1'b0;
      ce  <= 1'b0;
    end else if (hit) begin
      ale <= ctl[2];
      cle <= ctl[1];
      ce  <= ctl[0];
    end
  end
endmodule

// File: rtl/gpio_pm_sclk.sv
module gpio_pm_sclk (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic old_lvl,
  input  logic new_lvl,
  input  logic new_data,
  output logic sclk,
  output logic sdo,
  output logic edge_stb
);
  logic toggle;
  assign toggle = hit && (new_lvl != old_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk     <= 1'b0;
      sdo      <= 1'b0;
      edge_stb <= 1'b0;
    end else begin
      edge_stb <= toggle;
      if (toggle) begin
        sclk <= new_lvl;
        sdo  <= new_data;
      end
    end
  end
endmodule

// File: rtl/gpio_pm_rdmux.sv
module gpio_pm_rdmux #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rword,
  input  logic [DATA_W-1:0] a_dout,
  input  logic [DATA_W-1:0] a_oe,
  input  logic [DATA_W-1:0] d_dout,
  input  logic [DATA_W-1:0] d_oe,
  input  logic              ready,
  input  logic              sret,
  output logic [DATA_W-1:0] rdata
);
  import gpio_pm_pkg::*;

  logic [DATA_W-1:0] pins_a, pins_d, sel;

  always_comb begin
    pins_a = a_dout & a_oe;
    pins_a[BIT_RDY] = pins_a[BIT_RDY] | ready;
    pins_d = d_dout & d_oe;
    pins_d[BIT_SRET] = pins_d[BIT_SRET] | sret;
    if (idx == IDX_W'(IDX_A_PINS))      sel = pins_a;
    else if (idx == IDX_W'(IDX_D_PINS)) sel = pins_d;
    else                                sel = rword;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= sel;
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int WIN_BYTES = 92
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              nand_ready_i,
  output logic              nand_ale_o,
  output logic              nand_cle_o,
  output logic              nand_ce_o,
  input  logic              sens_sdi_i,
  output logic              sens_sclk_o,
  output logic              sens_sdo_o,
  output logic              sens_edge_o
);
  import gpio_pm_pkg::*;

  localparam int IDX_W     = ADDR_W - 2;
  localparam int NUM_WORDS = WIN_BYTES / 4;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rword, a_dout, a_oe, d_dout, d_oe;
  logic              hit_a, hit_d;
  logic              unused_lsb;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign hit_a      = bus_we && (idx == IDX_W'(IDX_A_DOUT));
  assign hit_d      = bus_we && (idx == IDX_W'(IDX_D_DOUT));

  gpio_pm_regs #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .idx(idx), .wdata(bus_wdata),
    .rword(rword), .a_dout(a_dout), .a_oe(a_oe), .d_dout(d_dout), .d_oe(d_oe)
  );

  gpio_pm_nand u_nand (
    .clk(clk), .rst(rst), .hit(hit_a),
    .ctl({bus_wdata[BIT_ALE], bus_wdata[BIT_CLE], bus_wdata[BIT_CE]}),
    .ale(nand_ale_o), .cle(nand_cle_o), .ce(nand_ce_o)
  );

  gpio_pm_sclk u_sclk (
    .clk(clk), .rst(rst), .hit(hit_d),
    .old_lvl(d_dout[BIT_SCLK]), .new_lvl(bus_wdata[BIT_SCLK]),
    .new_data(bus_wdata[BIT_SDATA]),
    .sclk(sens_sclk_o), .sdo(sens_sdo_o), .edge_stb(sens_edge_o)
  );

  gpio_pm_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdmux (
    .clk(clk), .rst(rst), .re(bus_re), .idx(idx), .rword(rword),
    .a_dout(a_dout), .a_oe(a_oe), .d_dout(d_dout), .d_oe(d_oe),
    .ready(nand_ready_i), .sret(sens_sdi_i), .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              nand_ale_o,
  input logic              nand_cle_o,
  input logic              nand_ce_o,
  input logic              sens_sclk_o,
  input logic              sens_sdo_o,
  input logic              sens_edge_o
);
  import gpio_pm_pkg::*;

  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !nand_ale_o && !nand_cle_o && !nand_ce_o &&
             !sens_sclk_o && !sens_sdo_o && !sens_edge_o)); // R1

  AST_NAND_LINES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && widx == (ADDR_W-2)'(IDX_A_DOUT)) |=>
      (nand_ale_o == $past(bus_wdata[BIT_ALE]) &&
       nand_cle_o == $past(bus_wdata[BIT_CLE]) &&
       nand_ce_o  == $past(bus_wdata[BIT_CE]))); // R6

  AST_EDGE_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && widx == (ADDR_W-2)'(IDX_D_DOUT) && bus_wdata[BIT_SCLK] != sens_sclk_o) |=>
      (sens_edge_o && sens_sdo_o == $past(bus_wdata[BIT_SDATA]))); // R7

  AST_EDGE_MOVES_CLK: assert property (@(posedge clk) disable iff (rst)
    sens_edge_o |-> (sens_sclk_o != $past(sens_sclk_o))); // R7

  AST_NO_EDGE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sens_edge_o |-> ($stable(sens_sclk_o) && $stable(sens_sdo_o))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_re) |-> $stable(bus_rdata)); // R9
endmodule

bind gpio_pinmux gpio_pinmux_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .nand_ale_o(nand_ale_o), .nand_cle_o(nand_cle_o), .nand_ce_o(nand_ce_o),
  .sens_sclk_o(sens_sclk_o), .sens_sdo_o(sens_sdo_o), .sens_edge_o(sens_edge_o)
);

// File: tb/test_gpio_pinmux.sv
`timescale 1ns/1ps
module test_gpio_pinmux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        nand_ready_i = 1'b0, sens_sdi_i = 1'b0;
  logic        nand_ale_o, nand_cle_o, nand_ce_o;
  logic        sens_sclk_o, sens_sdo_o, sens_edge_o;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_pend = 1'b0;

  always #2 clk = ~clk;

  gpio_pinmux i_gpio_pinmux (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .nand_ready_i(nand_ready_i), .nand_ale_o(nand_ale_o),
    .nand_cle_o(nand_cle_o), .nand_ce_o(nand_ce_o),
    .sens_sdi_i(sens_sdi_i), .sens_sclk_o(sens_sclk_o),
    .sens_sdo_o(sens_sdo_o), .sens_edge_o(sens_edge_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data in the cycle after each sampled read strobe
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hx, "R9 unexpected read");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
    rd_pend = bus_re;
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic rw(input logic [6:0] a, input logic [31:0] d,
                    input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic pins(input logic [2:0] exp, input string tag);
    check({29'd0, nand_ale_o, nand_cle_o, nand_ce_o}, {29'd0, exp}, tag);
  endtask

  task automatic ser(input logic [2:0] exp, input string tag);
    check({29'd0, sens_edge_o, sens_sclk_o, sens_sdo_o}, {29'd0, exp}, tag);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    pins(3'b000, "R1 nand lines");
    ser(3'b000, "R1 serial lines");
    check(bus_rdata, 32'h0, "R1 rdata");
    rd(7'h00, 32'h0, "R1 porta dout");
    rd(7'h48, 32'h0, "R1 portd oe");
    // R6 flash control lines
    wr(7'h08, 32'hFF);
    wr(7'h00, 32'h70);
    pins(3'b111, "R6 all high");
    wr(7'h00, 32'h40);
    pins(3'b100, "R6 ale only");
    // R4 pin view of port A
    nand_ready_i = 1'b1;
    rd(7'h04, 32'hC0, "R4 ready set");
    wr(7'h08, 32'h0F);
    wr(7'h00, 32'hF5);
    pins(3'b111, "R6 from F5");
    nand_ready_i = 1'b0;
    rd(7'h04, 32'h05, "R4 masked by enable");
    wr(7'h04, 32'hFFFF_FFFF);
    rd(7'h04, 32'h05, "R3 pin index write has no effect on read");
    // R7 and R8 serial clock
    wr(7'h40, 32'h12);
    ser(3'b111, "R7 rising edge");
    @(posedge clk); #1;
    ser(3'b011, "R7 strobe one cycle");
    wr(7'h40, 32'h02);
    ser(3'b011, "R8 no edge, data kept");
    rd(7'h40, 32'h02, "R8 value stored");
    wr(7'h40, 32'h00);
    ser(3'b100, "R7 falling edge");
    // R5 pin view of port D
    wr(7'h48, 32'hFF);
    rd(7'h48, 32'hFF, "R3 portd oe readback");
    wr(7'h40, 32'h0C);
    ser(3'b000, "R8 no toggle");
    sens_sdi_i = 1'b1;
    rd(7'h44, 32'h1C, "R5 return set");
    sens_sdi_i = 1'b0;
    rd(7'h44, 32'h0C, "R5 return clear");
    // R2 low address bits ignored
    wr(7'h15, 32'hA5A5_0001);
    rd(7'h14, 32'hA5A5_0001, "R2 aligned read");
    rd(7'h17, 32'hA5A5_0001, "R2 unaligned read");
    // R3 window edges
    wr(7'h58, 32'hDEAD_BEEF);
    rd(7'h58, 32'hDEAD_BEEF, "R3 last word");
    wr(7'h5C, 32'h0000_1234);
    rd(7'h5C, 32'h0, "R3 beyond window");
    // R9 collision and hold
    rw(7'h14, 32'h0000_2222, 32'hA5A5_0001, "R9 read before write");
    rd(7'h14, 32'h0000_2222, "R9 write landed");
    repeat (2) @(posedge clk);
    #1 check(bus_rdata, 32'h0000_2222, "R9 rdata held");
    rw(7'h40, 32'h0000_0002, 32'h0000_000C, "R9 collision on port D latch");
    ser(3'b110, "R7 edge during collision");
    repeat (3) @(posedge clk);
    check(exp_q.size(), 0, "R9 all reads returned");
    finish_run();
  end
endmodule